// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start Qualification

This block takes in asynchronous serial frames (one low start bit, eight data bits least significant first, one high stop bit) and turns each into a parallel byte. The line is watched at sixteen ticks per bit period. The ticks come from a free-running counter that reloads from a programmable divider, so one build serves rates such as 9600, 14400, 19200 or 38400 bit/s from the same system clock.

A falling edge alone does not start a frame, because a short glitch on the line would otherwise be taken as a start bit. The edge opens a qualification window one bit period long. The block counts the low samples in that window and goes on to the data bits only when that count is strictly greater than a programmable threshold. If the count is too low, the block returns to watching the line and gives no output.

A good frame gives the byte with a one-clock valid pulse, and the byte stays on the output until the next good frame. A low stop bit gives a one-clock framing-error pulse instead, with no valid pulse and no change to the byte.

Top module: `uart_rx_qual`

## Requirements
- R1: While reset is held and after it is released, `data_o` is 0 and `valid_o` and `err_o` are 0 until a frame completes.
- R2: `rx_i` passes through a two-flop synchronizer. One oversampling tick occurs every `div_i`+1 clocks (`div_i` >= 1), and one bit period is 16 ticks.
- R3: A falling edge on the synchronized line, seen while idle, opens a window of the next 16 ticks, and the block counts the low samples in that window.
- R4: The start bit is accepted only when the low-sample count is strictly greater than `thresh_i`. Otherwise the block returns to idle without asserting `valid_o` or `err_o`, and it is ready for the next falling edge.
- R5: After acceptance, 8 data bits are taken least significant bit first, each sampled on the 8th tick of its 16-tick period.
- R6: If the stop bit, sampled on its 8th tick, is high, `data_o` takes the received byte and `valid_o` is high for exactly one clock.
- R7: If the stop bit is low, `err_o` is high for exactly one clock, `valid_o` stays low and `data_o` is unchanged.
- R8: `data_o` changes only together with a `valid_o` pulse.
- R9: Falling edges during the window, the data bits or the stop bit do not restart reception.
- R10: A new `div_i` value changes the bit rate with no other change to the design.
- R11: `valid_o` and `err_o` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Raw asynchronous serial line, idle high |
| div_i | input | DIV_W (16) | Tick divider; tick period is div_i+1 clocks |
| thresh_i | input | $clog2(OVS+1) (5) | Low-sample count that must be exceeded to accept a start bit |
| data_o | output | DATA_W (8) | Last good received byte |
| valid_o | output | 1 | One-clock pulse when data_o takes a new byte |
| err_o | output | 1 | One-clock pulse when a frame ends with a low stop bit |

## Verification
The bench uses the default parameters: eight data bits, sixteen ticks per bit and a 16-bit divider. It sets the divider at run time to 3 and then 7, giving 64- and 128-clock bit periods. Those periods keep every frame short, and they show that a change of rate needs only a new divider value. The threshold is set at run time to 8, 10, 12, 14 and 16. Low pulses of a known length then fall on both sides of the acceptance rule, and a threshold of 16 shows that the comparison is strictly greater-than, because sixteen samples can never exceed it.

// File: rtl/uart_rx_qual_pkg.sv
// Package: shared types for the qualified serial receiver.
// Assumes: a frame has one start bit, DATA_W data bits and one stop bit.
package uart_rx_qual_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_DATA = 2'd2,
        ST_STOP = 2'd3
    } rxq_state_t;

endpackage

// File: rtl/rxq_sync.sv
// Module: rxq_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes: the input is a slow level such as a serial line; reset value is
// the idle level IDLE_LVL.
module rxq_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level along the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LVL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rxq_tick_gen.sv
// Module: rxq_tick_gen
// Free-running oversampling tick source. Gives a one-clock tick every
// div_i+1 clocks. The divider is reloaded at each tick, so a new value
// takes effect after the current period ends.
// Assumes: div_i >= 1, so ticks are at least two clocks apart.
module rxq_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // Count down and reload from the divider, marking each reload as a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= div_i;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_start_qual.sv
// Module: rxq_start_qual
// Start-bit qualifier. A start pulse opens a window of OVS ticks, and the
// module counts the low samples in it. On the last tick it gives a done
// pulse, with pass set when the count is strictly above the threshold.
// Assumes: start_i comes only while the window is closed; ticks are at
// least two clocks apart.
module rxq_start_qual #(
    parameter int OVS = 16,
    localparam int CNT_W = $clog2(OVS),
    localparam int ZC_W  = $clog2(OVS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            tick_i,
    input  logic            line_i,
    input  logic [ZC_W-1:0] thresh_i,
    output logic            done_o,
    output logic            pass_o
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);

    logic             open_q;
    logic [CNT_W-1:0] tcnt_q;
    logic [ZC_W-1:0]  zeros_q;
    logic [ZC_W-1:0]  zeros_nxt;

    // Low count including the sample taken on the current tick
    always_comb begin
        zeros_nxt = zeros_q + {{(ZC_W-1){1'b0}}, ~line_i};
    end

    // Open the window, count low samples and give the decision at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            tcnt_q  <= '0;
            zeros_q <= '0;
            done_o  <= 1'b0;
            pass_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !open_q) begin
                open_q  <= 1'b1;
                tcnt_q  <= '0;
                zeros_q <= '0;
                pass_o  <= 1'b0;
            end else if (open_q && tick_i) begin
                zeros_q <= zeros_nxt;
                if (tcnt_q == LAST_TICK) begin
                    open_q <= 1'b0;
                    tcnt_q <= '0;
                    done_o <= 1'b1;
                    pass_o <= (zeros_nxt > thresh_i);
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rxq_frame_fsm.sv
// Module: rxq_frame_fsm
// Frame sequencer. From idle, a falling edge starts qualification. A passed
// window leads to DATA_W data bits, LSB first, each sampled mid-bit, and
// then a mid-bit stop sample that gives either a byte with a valid pulse or
// a framing-error pulse.
// Assumes: fall_i and line_i are synchronous; the qualifier's done/pass
// come one clock after its final tick.
module rxq_frame_fsm
    import uart_rx_qual_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    localparam int CNT_W  = $clog2(OVS),
    localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              fall_i,
    input  logic              qual_done_i,
    input  logic              qual_pass_i,
    output logic              qual_start_o,
    output rxq_state_t        state_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0]  MID_TICK  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0]  LAST_TICK = CNT_W'(OVS - 1);
    localparam logic [BIDX_W-1:0] LAST_BIT  = BIDX_W'(DATA_W - 1);

    rxq_state_t        state_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [DATA_W-1:0] shift_q;

    // Qualification begins only on an edge seen while idle
    always_comb begin
        qual_start_o = (state_q == ST_IDLE) && fall_i;
    end

    // Sequence through qualification, data bits and stop bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shift_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (qual_start_o) begin
                        state_q <= ST_QUAL;
                    end
                end
                ST_QUAL: begin
                    if (qual_done_i) begin
                        tcnt_q  <= '0;
                        bidx_q  <= '0;
                        state_q <= qual_pass_i ? ST_DATA : ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (tick_i) begin
                        if (tcnt_q == MID_TICK) begin
                            shift_q <= {line_i, shift_q[DATA_W-1:1]};
                        end
                        if (tcnt_q == LAST_TICK) begin
                            tcnt_q <= '0;
                            if (bidx_q == LAST_BIT) begin
                                state_q <= ST_STOP;
                            end else begin
                                bidx_q <= bidx_q + 1'b1;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_i) begin
                        if (tcnt_q == MID_TICK) begin
                            tcnt_q  <= '0;
                            state_q <= ST_IDLE;
                            if (line_i) begin
                                data_o  <= shift_q;
                                valid_o <= 1'b1;
                            end else begin
                                err_o <= 1'b1;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/uart_rx_qual.sv
// Module: uart_rx_qual (top)
// Qualified oversampled serial receiver: synchronizer, edge detector, tick
// generator, start qualifier and frame sequencer.
// Assumes: idle-high line; div_i >= 1; thresh_i is stable during a frame.
module uart_rx_qual
    import uart_rx_qual_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DIV_W  = 16,
    localparam int ZC_W  = $clog2(OVS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [ZC_W-1:0]   thresh_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);

    logic       line_s;
    logic       line_d;
    logic       fall;
    logic       tick;
    logic       qual_start;
    logic       qual_done;
    logic       qual_pass;
    rxq_state_t fsm_state;

    rxq_sync #(
        .STAGES  (2),
        .IDLE_LVL(1'b1)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(rx_i),
        .sync_o (line_s)
    );

    // Delay the synchronized line by one clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d <= 1'b1;
        end else begin
            line_d <= line_s;
        end
    end

    assign fall = line_d & ~line_s;

    rxq_tick_gen #(
        .DIV_W(DIV_W)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (div_i),
        .tick_o(tick)
    );

    rxq_start_qual #(
        .OVS(OVS)
    ) i_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (qual_start),
        .tick_i  (tick),
        .line_i  (line_s),
        .thresh_i(thresh_i),
        .done_o  (qual_done),
        .pass_o  (qual_pass)
    );

    rxq_frame_fsm #(
        .DATA_W(DATA_W),
        .OVS   (OVS)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .line_i      (line_s),
        .fall_i      (fall),
        .qual_done_i (qual_done),
        .qual_pass_i (qual_pass),
        .qual_start_o(qual_start),
        .state_o     (fsm_state),
        .data_o      (data_o),
        .valid_o     (valid_o),
        .err_o       (err_o)
    );

endmodule

// File: rtl/uart_rx_qual_chk.sv
// Module: uart_rx_qual_chk
// Property checker for uart_rx_qual, attached by bind below.
module uart_rx_qual_chk
    import uart_rx_qual_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_o,
    input logic              valid_o,
    input logic              err_o,
    input rxq_state_t        state
);

    // R11: never both outcomes at once
    p_excl_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    // R6: valid lasts one clock
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: error lasts one clock and follows a stop-bit sample
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    p_err_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(state) == ST_STOP);

    // R8: byte holds except on a valid pulse
    p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    // R9: qualification is entered only from idle
    p_qual_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL && $past(state) != ST_QUAL) |-> $past(state) == ST_IDLE);

    // R4: data bits follow only a qualification window
    p_data_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_QUAL);

endmodule

bind uart_rx_qual uart_rx_qual_chk #(
    .DATA_W(DATA_W)
) i_uart_rx_qual_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_o (data_o),
    .valid_o(valid_o),
    .err_o  (err_o),
    .state  (fsm_state)
);

// File: tb/test_uart_rx_qual.sv
// Directed bench for uart_rx_qual: one task per scenario.
module test_uart_rx_qual;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int ZC_W   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx = 1'b1;
    logic [DIV_W-1:0]  div = 16'd3;
    logic [ZC_W-1:0]   thresh = 5'd8;
    logic [DATA_W-1:0] data_o;
    logic              valid_o;
    logic              err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_valid  = 0;
    int n_err    = 0;
    int n_both   = 0;
    int n_wide   = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0;
    logic prev_err   = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_qual i_uart_rx_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_i    (rx),
        .div_i   (div),
        .thresh_i(thresh),
        .data_o  (data_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                n_valid++;
                last_byte = data_o;
            end
            if (err_o) n_err++;
            if (valid_o && err_o) n_both++;
            if ((valid_o && prev_valid) || (err_o && prev_err)) n_wide++;
        end
        prev_valid = valid_o;
        prev_err   = err_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_lvl, input int bclk);
        rx = 1'b0;
        hold(bclk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            hold(bclk);
        end
        rx = stop_lvl;
        hold(bclk);
        rx = 1'b1;
        hold(bclk * 3);
    endtask

    task automatic low_pulse(input int clks, input int bclk);
        rx = 1'b0;
        hold(clks);
        rx = 1'b1;
        hold(bclk * 12);
    endtask

    task automatic t_reset();
        check("R1 data after reset", data_o, 0);
        check("R1 valid after reset", valid_o, 0);
        check("R1 err after reset", err_o, 0);
    endtask

    task automatic t_good_frame(input logic [7:0] b, input int bclk, input string req);
        int v0 = n_valid;
        int e0 = n_err;
        send_frame(b, 1'b1, bclk);
        check({req, " valid count"}, n_valid - v0, 1);
        check({req, " byte"}, last_byte, b);
        check({req, " data_o"}, data_o, b);
        check({req, " no err"}, n_err - e0, 0);
    endtask

    task automatic t_glitch();
        int v0 = n_valid;
        int e0 = n_err;
        logic [7:0] keep = data_o;
        thresh = 5'd8;
        low_pulse(24, 64);
        check("R4 glitch no valid", n_valid - v0, 0);
        check("R4 glitch no err", n_err - e0, 0);
        check("R8 glitch keeps byte", data_o, keep);
        t_good_frame(8'h3C, 64, "R3 idle after reject");
    endtask

    task automatic t_threshold();
        int v0;
        thresh = 5'd12;
        v0 = n_valid;
        low_pulse(48, 64);
        check("R4 12-tick low below 12", n_valid - v0, 0);
        thresh = 5'd10;
        v0 = n_valid;
        low_pulse(48, 64);
        check("R3 12-tick low above 10", n_valid - v0, 1);
        check("R5 all-high data", last_byte, 8'hFF);
        thresh = 5'd16;
        v0 = n_valid;
        send_frame(8'hFF, 1'b1, 64);
        check("R4 threshold 16 never exceeded", n_valid - v0, 0);
        thresh = 5'd14;
        t_good_frame(8'hFF, 64, "R4 threshold 14");
        thresh = 5'd8;
    endtask

    task automatic t_framing();
        int v0 = n_valid;
        int e0 = n_err;
        logic [7:0] keep = data_o;
        send_frame(8'h81, 1'b0, 64);
        check("R7 err count", n_err - e0, 1);
        check("R7 no valid", n_valid - v0, 0);
        check("R8 byte kept on error", data_o, keep);
    endtask

    initial begin
        hold(10);
        t_reset();
        rst_n = 1'b1;
        hold(10);
        t_reset();
        t_good_frame(8'hA5, 64, "R5 R6 frame A5");
        t_good_frame(8'h55, 64, "R9 edges in data");
        t_glitch();
        t_threshold();
        t_framing();
        div = 16'd7;
        hold(20);
        t_good_frame(8'hC3, 128, "R10 divider 7");
        t_good_frame(8'h01, 128, "R2 slow rate");
        check("R11 both outputs together", n_both, 0);
        check("R6 pulse width", n_wide, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule